// File: doc/BRIEF.md
# Bufferless Circuit-Switched Mesh Router

This block is one switch of a two-dimensional mesh interconnect that works by connection setup, not by packet buffering. Each of its four sides (north, east, south, west) has an incoming forward channel, an outgoing forward channel and a reverse signalling pair (acknowledge and negative acknowledge). A sender opens a connection by sending a setup flit that carries the destination coordinates. The switch routes X first, then Y, and tries to claim the chosen output in the same cycle. If the claim succeeds, the setup flit passes through at once and the path stays in place. All later flits of that input follow the path with no storage, until the sender sends a flit marked as the tail.

A setup that cannot be served gets a one-cycle negative acknowledge on its own reverse channel in the cycle it arrives, and the switch forgets it. A setup is refused when its output is held, when it loses a same-cycle contest, or when it has no legal route. A positive acknowledge arriving from downstream on a held output is passed back to the owning input in the same cycle. A downstream refusal is passed back the same way and also tears the path down.

The forward channels use valid/ready. A transfer happens in a cycle where both valid and ready are high. On a held path or a winning setup, `in_ready` follows the `out_ready` of the claimed output, so downstream back-pressure reaches the sender combinationally. In that case the flit stays on the input and must be held stable. A refused setup or a stray flit is consumed at once: its `in_ready` is high.

Top module: `mesh_circuit_router`

## Requirements
- R1: After reset, or while reset is held, no path is held: every `out_valid`, `in_ack` and `in_nack` is low and every `in_ready` is high.
- R2: Flit bit FLIT_W-1 is the start bit, bit FLIT_W-2 is the tail bit, bits [COORD_W-1:0] hold destination X and bits [2*COORD_W-1:COORD_W] hold destination Y. Port index 0..3 is north, east, south, west. Routing sends a larger X east and a smaller X west. When X matches, a larger Y goes north and a smaller Y goes south. A setup that wins a free output appears on that output in the same cycle.
- R3: A setup accepted with `out_ready` high holds the path from the next cycle on. Every later flit of that input, including one whose start bit is set, goes straight to the held output in the same cycle.
- R4: A setup aimed at an output held by another input is refused: `in_nack` pulses for that cycle, `in_ready` is high and nothing is forwarded. The switch keeps no memory of the refusal.
- R5: Setups that reach the same free output in the same cycle are decided in that cycle by fixed priority: north, then east, south, west. Every loser is refused as in R4.
- R6: A setup whose destination equals the switch's own coordinates, or whose route points back out of the side it arrived on, is refused.
- R7: With `out_ready` low on the claimed output, the input's `in_ready` is low. A stalled winning setup is neither refused nor recorded as held.
- R8: `out_ack` on a held output appears on `in_ack` of its owner in the same cycle. `out_ack` on an output that is not held has no effect.
- R9: Accepting a tail flit on a held path frees the output from the next cycle. A setup for that output in the tail's own cycle is refused, and one in the following cycle is accepted.
- R10: `out_nack` on a held output appears on `in_nack` of the owner in the same cycle and frees the output from the next cycle.
- R11: A flit with the start bit clear on an input that holds no path is consumed (`in_ready` high) with no output and no `in_nack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 4 | Forward valid per incoming side |
| in_ready | output | 4 | Forward ready per incoming side |
| in_data | input | 4*FLIT_W | Incoming flits, side i at bits [i*FLIT_W +: FLIT_W] |
| in_ack | output | 4 | Positive acknowledge back toward each sender |
| in_nack | output | 4 | Negative acknowledge back toward each sender |
| out_valid | output | 4 | Forward valid per outgoing side |
| out_ready | input | 4 | Forward ready from each downstream neighbour |
| out_data | output | 4*FLIT_W | Outgoing flits, side o at bits [o*FLIT_W +: FLIT_W] |
| out_ack | input | 4 | Positive acknowledge from downstream per side |
| out_nack | input | 4 | Negative acknowledge from downstream per side |

## Verification
Two functions can land on the same output in one cycle: the release of a held path by its tail flit, and a new setup from another side that wants that output. The bench drives both in one cycle and expects the newcomer to be refused, since the output is still held until the edge. It then repeats the same setup in the next cycle and expects it to be accepted and forwarded. A same-cycle contest of three setups is also judged, against the fixed priority and against the independent forwarding of the setup that aims elsewhere.

// File: rtl/mcr_pkg.sv
package mcr_pkg;
  localparam int NP = 4;
  localparam int PW = $clog2(NP);
  typedef enum logic [PW-1:0] {
    SIDE_N = 2'd0,
    SIDE_E = 2'd1,
    SIDE_S = 2'd2,
    SIDE_W = 2'd3
  } side_e;
endpackage

// File: rtl/mcr_route.sv
module mcr_route import mcr_pkg::*; #(
  parameter int COORD_W = 3,
  parameter int HOME_X  = 1,
  parameter int HOME_Y  = 1,
  parameter int ARRIVE  = 0
) (
  input  logic [2*COORD_W-1:0] dest,
  output logic [NP-1:0]        want
);
  localparam logic [COORD_W-1:0] HX = COORD_W'(HOME_X);
  localparam logic [COORD_W-1:0] HY = COORD_W'(HOME_Y);
  localparam side_e BACK = side_e'(ARRIVE);

  logic [COORD_W-1:0] dx, dy;
  side_e              pick;
  logic               found;

  always_comb begin
    dx    = dest[COORD_W-1:0];
    dy    = dest[2*COORD_W-1:COORD_W];
    found = 1'b1;
    pick  = SIDE_N;
    if (dx > HX)      pick = SIDE_E;
    else if (dx < HX) pick = SIDE_W;
    else if (dy > HY) pick = SIDE_N;
    else if (dy < HY) pick = SIDE_S;
    else              found = 1'b0;
    want = '0;
    if (found && (pick != BACK)) want[pick] = 1'b1;
  end
endmodule

// File: rtl/mcr_alloc.sv
module mcr_alloc import mcr_pkg::*; (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NP-1:0]          req,
  input  logic [NP-1:0][NP-1:0]  want,
  input  logic [NP-1:0]          in_valid,
  input  logic [NP-1:0]          in_tail,
  input  logic [NP-1:0]          out_ready,
  input  logic [NP-1:0]          out_nack,
  output logic [NP-1:0]          conn,
  output logic [NP-1:0]          path,
  output logic [NP-1:0][PW-1:0]  dir,
  output logic [NP-1:0]          reject
);
  logic [NP-1:0]          conn_q;
  logic [NP-1:0][PW-1:0]  route_q;
  logic [NP-1:0][PW-1:0]  tgt;
  logic [NP-1:0][NP-1:0]  cand;
  logic [NP-1:0][NP-1:0]  holder;
  logic [NP-1:0]          busy;
  logic [NP-1:0]          grant;
  logic [NP-1:0]          claim;
  logic [NP-1:0]          drop;

  always_comb begin
    for (int i = 0; i < NP; i++) begin
      tgt[i] = '0;
      for (int o = 0; o < NP; o++)
        if (want[i][o]) tgt[i] = PW'(o);
    end
    for (int o = 0; o < NP; o++) begin
      for (int i = 0; i < NP; i++) begin
        cand[o][i]   = req[i] & want[i][o];
        holder[o][i] = conn_q[i] & (route_q[i] == PW'(o));
      end
      busy[o] = |holder[o];
    end
  end

  // fixed priority: lowest side index wins each output
  always_comb begin
    logic first;
    grant = '0;
    for (int o = 0; o < NP; o++) begin
      first = 1'b1;
      for (int i = 0; i < NP; i++) begin
        if (cand[o][i] && first) begin
          first = 1'b0;
          if (!busy[o]) grant[i] = 1'b1;
        end
      end
    end
  end

  always_comb begin
    for (int i = 0; i < NP; i++) begin
      dir[i]   = conn_q[i] ? route_q[i] : tgt[i];
      claim[i] = grant[i] & out_ready[tgt[i]];
      drop[i]  = conn_q[i] & ((in_valid[i] & in_tail[i] & out_ready[route_q[i]])
                              | out_nack[route_q[i]]);
    end
    reject = req & ~grant;
    path   = conn_q | grant;
    conn   = conn_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      conn_q  <= '0;
      route_q <= '0;
    end else begin
      for (int i = 0; i < NP; i++) begin
        if (claim[i]) begin
          conn_q[i]  <= 1'b1;
          route_q[i] <= tgt[i];
        end else if (drop[i]) begin
          conn_q[i]  <= 1'b0;
        end
      end
    end
  end

  for (genvar g = 0; g < NP; g++) begin : g_chk
    a_r3_claim_holds: assert property (@(posedge clk) disable iff (!rst_n)
      claim[g] |=> (conn[g] && dir[g] == $past(tgt[g])));
    a_r9_release_next: assert property (@(posedge clk) disable iff (!rst_n)
      drop[g] |=> !conn[g]);
    a_r4_one_owner: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(holder[g]));
    a_r5_one_winner: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant & cand[g]));
  end
endmodule

// File: rtl/mcr_xbar.sv
module mcr_xbar import mcr_pkg::*; #(
  parameter int FLIT_W = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NP-1:0]               in_valid,
  input  logic [NP-1:0][FLIT_W-1:0]   in_data,
  input  logic [NP-1:0]               conn,
  input  logic [NP-1:0]               path,
  input  logic [NP-1:0][PW-1:0]       dir,
  input  logic [NP-1:0]               reject,
  input  logic [NP-1:0]               out_ready,
  input  logic [NP-1:0]               out_ack,
  input  logic [NP-1:0]               out_nack,
  output logic [NP-1:0]               out_valid,
  output logic [NP-1:0][FLIT_W-1:0]   out_data,
  output logic [NP-1:0]               in_ready,
  output logic [NP-1:0]               in_ack,
  output logic [NP-1:0]               in_nack
);
  always_comb begin
    for (int o = 0; o < NP; o++) begin
      out_valid[o] = 1'b0;
      out_data[o]  = '0;
      for (int i = 0; i < NP; i++) begin
        if (path[i] && dir[i] == PW'(o)) begin
          out_valid[o] = in_valid[i];
          out_data[o]  = in_data[i];
        end
      end
    end
    for (int i = 0; i < NP; i++) begin
      in_ready[i] = path[i] ? out_ready[dir[i]] : 1'b1;
      in_ack[i]   = conn[i] & out_ack[dir[i]];
      in_nack[i]  = reject[i] | (conn[i] & out_nack[dir[i]]);
    end
  end

  for (genvar g = 0; g < NP; g++) begin : g_chk
    a_r4_refused_consumed: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid[g] && reject[g]) |-> (in_ready[g] && !path[g]));
  end
endmodule

// File: rtl/mesh_circuit_router.sv
module mesh_circuit_router import mcr_pkg::*; #(
  parameter int FLIT_W  = 16,
  parameter int COORD_W = 3,
  parameter int HOME_X  = 1,
  parameter int HOME_Y  = 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NP-1:0]         in_valid,
  output logic [NP-1:0]         in_ready,
  input  logic [NP*FLIT_W-1:0]  in_data,
  output logic [NP-1:0]         in_ack,
  output logic [NP-1:0]         in_nack,
  output logic [NP-1:0]         out_valid,
  input  logic [NP-1:0]         out_ready,
  output logic [NP*FLIT_W-1:0]  out_data,
  input  logic [NP-1:0]         out_ack,
  input  logic [NP-1:0]         out_nack
);
  localparam int START_BIT = FLIT_W - 1;
  localparam int TAIL_BIT  = FLIT_W - 2;

  logic [NP-1:0][FLIT_W-1:0] in_flit, out_flit;
  logic [NP-1:0][NP-1:0]     want;
  logic [NP-1:0][PW-1:0]     dir;
  logic [NP-1:0]             req, tail, conn, path, reject;

  assign in_flit  = in_data;
  assign out_data = out_flit;

  for (genvar g = 0; g < NP; g++) begin : g_side
    assign tail[g] = in_flit[g][TAIL_BIT];
    assign req[g]  = in_valid[g] & in_flit[g][START_BIT] & ~conn[g];
    mcr_route #(
      .COORD_W(COORD_W), .HOME_X(HOME_X), .HOME_Y(HOME_Y), .ARRIVE(g)
    ) u_route (
      .dest (in_flit[g][2*COORD_W-1:0]),
      .want (want[g])
    );
  end

  mcr_alloc u_alloc (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (req),
    .want      (want),
    .in_valid  (in_valid),
    .in_tail   (tail),
    .out_ready (out_ready),
    .out_nack  (out_nack),
    .conn      (conn),
    .path      (path),
    .dir       (dir),
    .reject    (reject)
  );

  mcr_xbar #(.FLIT_W(FLIT_W)) u_xbar (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_data   (in_flit),
    .conn      (conn),
    .path      (path),
    .dir       (dir),
    .reject    (reject),
    .out_ready (out_ready),
    .out_ack   (out_ack),
    .out_nack  (out_nack),
    .out_valid (out_valid),
    .out_data  (out_flit),
    .in_ready  (in_ready),
    .in_ack    (in_ack),
    .in_nack   (in_nack)
  );
endmodule

// File: tb/test_mesh_circuit_router.sv
`timescale 1ns/1ps
module test_mesh_circuit_router;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  iv, irdy, iack, inack, ov, ordy, oack, onack;
  logic [63:0] id, od;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  mesh_circuit_router i_mesh_circuit_router (
    .clk(clk), .rst_n(rst_n),
    .in_valid(iv), .in_ready(irdy), .in_data(id),
    .in_ack(iack), .in_nack(inack),
    .out_valid(ov), .out_ready(ordy), .out_data(od),
    .out_ack(oack), .out_nack(onack)
  );

  typedef struct packed {
    logic [3:0]  iv;
    logic [63:0] id;     // {W,S,E,N}
    logic [3:0]  ordy;
    logic [3:0]  oack;
    logic [3:0]  onack;
    logic [3:0]  e_ov;
    logic [7:0]  e_src;  // source side per valid output, 2 bits each
    logic [3:0]  e_rdy;
    logic [3:0]  e_ack;
    logic [3:0]  e_nack;
    logic [7:0]  rq;
  } row_t;

  localparam int NROW = 15;
  // flit: bit15 start, bit14 tail, [2:0] dest X, [5:3] dest Y; home (1,1)
  localparam row_t VEC [NROW] = '{
    // R6 east input routed back east
    '{4'b0010, 64'h0000_0000_800A_0000, 4'hF, 4'h0, 4'h0, 4'b0000, 8'h00, 4'hF, 4'h0, 4'b0010, 8'd6},
    // R2 north input opens a path east
    '{4'b0001, 64'h0000_0000_0000_800A, 4'hF, 4'h0, 4'h0, 4'b0010, 8'h00, 4'hF, 4'h0, 4'b0000, 8'd2},
    // R4 south setup to held east output, north data passes
    '{4'b0101, 64'h0000_800A_0000_1234, 4'hF, 4'h0, 4'h0, 4'b0010, 8'h00, 4'hF, 4'h0, 4'b0100, 8'd4},
    // R8 ack on held east and on free west
    '{4'b0000, 64'h0,                   4'hF, 4'b1010, 4'h0, 4'b0000, 8'h00, 4'hF, 4'b0001, 4'b0000, 8'd8},
    // R7 east downstream stalls
    '{4'b0001, 64'h0000_0000_0000_2222, 4'b1101, 4'h0, 4'h0, 4'b0010, 8'h00, 4'b1110, 4'h0, 4'b0000, 8'd7},
    // R3 start bit set on a held path is plain data
    '{4'b0001, 64'h0000_0000_0000_8003, 4'hF, 4'h0, 4'h0, 4'b0010, 8'h00, 4'hF, 4'h0, 4'b0000, 8'd3},
    // R9 tail and competing setup in one cycle
    '{4'b1001, 64'h800A_0000_0000_4001, 4'hF, 4'h0, 4'h0, 4'b0010, 8'h00, 4'hF, 4'h0, 4'b1000, 8'd9},
    // R9 retry one cycle later wins
    '{4'b1000, 64'h800A_0000_0000_0000, 4'hF, 4'h0, 4'h0, 4'b0010, 8'h0C, 4'hF, 4'h0, 4'b0000, 8'd9},
    // R5 east and south contest north; north input goes south
    '{4'b0111, 64'h0000_8011_8011_8001, 4'hF, 4'h0, 4'h0, 4'b0101, 8'h01, 4'hF, 4'h0, 4'b0100, 8'd5},
    // R10 downstream refusal on north output
    '{4'b0000, 64'h0,                   4'hF, 4'h0, 4'b0001, 4'b0000, 8'h00, 4'hF, 4'h0, 4'b0010, 8'd10},
    // R10 north output free again
    '{4'b0100, 64'h0000_8011_0000_0000, 4'hF, 4'h0, 4'h0, 4'b0001, 8'h02, 4'hF, 4'h0, 4'b0000, 8'd10},
    // R6 destination is this switch
    '{4'b0010, 64'h0000_0000_8009_0000, 4'hF, 4'h0, 4'h0, 4'b0000, 8'h00, 4'hF, 4'h0, 4'b0010, 8'd6},
    // R11 stray flit on idle input
    '{4'b0010, 64'h0000_0000_0055_0000, 4'hF, 4'h0, 4'h0, 4'b0000, 8'h00, 4'hF, 4'h0, 4'b0000, 8'd11},
    // R7 winning setup stalled by west downstream
    '{4'b0010, 64'h0000_0000_8008_0000, 4'b0111, 4'h0, 4'h0, 4'b1000, 8'h40, 4'b1101, 4'h0, 4'b0000, 8'd7},
    // R7 stalled setup left nothing held: data is stray
    '{4'b0010, 64'h0000_0000_0066_0000, 4'hF, 4'h0, 4'h0, 4'b0000, 8'h00, 4'hF, 4'h0, 4'b0000, 8'd7}
  };

  task automatic chk4(input string what, input int rq, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d %s actual=%b expected=%b", rq, what, act, exp);
    end
  endtask

  task automatic chk16(input string what, input int rq, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    iv = '0; id = '0; ordy = 4'hF; oack = '0; onack = '0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    idle_inputs();
    repeat (2) @(posedge clk);
    #1;
    // R1 reset state
    chk4("reset out_valid", 1, ov, 4'h0);
    chk4("reset in_ready", 1, irdy, 4'hF);
    chk4("reset in_ack", 1, iack, 4'h0);
    chk4("reset in_nack", 1, inack, 4'h0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int r = 0; r < NROW; r++) begin
      @(negedge clk);
      iv = VEC[r].iv; id = VEC[r].id; ordy = VEC[r].ordy;
      oack = VEC[r].oack; onack = VEC[r].onack;
      #1;
      chk4("out_valid", int'(VEC[r].rq), ov, VEC[r].e_ov);
      chk4("in_ready", int'(VEC[r].rq), irdy, VEC[r].e_rdy);
      chk4("in_ack", int'(VEC[r].rq), iack, VEC[r].e_ack);
      chk4("in_nack", int'(VEC[r].rq), inack, VEC[r].e_nack);
      for (int o = 0; o < 4; o++) begin
        if (VEC[r].e_ov[o]) begin
          int s;
          s = int'(VEC[r].e_src[2*o +: 2]);
          chk16("out_data", int'(VEC[r].rq), od[16*o +: 16], VEC[r].id[16*s +: 16]);
        end
      end
    end

    // R3 west input still holds east output
    @(negedge clk);
    idle_inputs();
    iv = 4'b1000; id = 64'h0088_0000_0000_0000;
    #1;
    chk4("held west->east valid", 3, ov, 4'b0010);
    chk16("held west->east data", 3, od[31:16], 16'h0088);

    // R1 reset clears held paths
    @(negedge clk);
    idle_inputs();
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk4("post-reset out_valid", 1, ov, 4'h0);
    chk4("post-reset in_ready", 1, irdy, 4'hF);
    @(negedge clk);
    iv = 4'b0001; id = 64'h0000_0000_0000_0077;
    #1;
    chk4("north data after reset is stray", 1, ov, 4'h0);
    chk4("no refusal for stray", 11, inack, 4'h0);
    @(negedge clk);
    iv = 4'b0001; id = 64'h0000_0000_0000_800A;
    #1;
    chk4("east output free after reset", 1, ov, 4'b0010);
    chk16("east output carries setup", 2, od[31:16], 16'h800A);

    @(negedge clk);
    idle_inputs();
    finish_run();
  end
endmodule